// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block watches four synchronized comparator indications: supply too high, supply too low, die temperature warning and die temperature shutdown. From them it produces one global output-disable signal for all half-bridge stages and a set of status flags for a host to read. Supply faults disable the outputs on the next clock. After the supply returns to its normal range, the outputs come back in one of two ways. In the automatic policy they return on their own. In the held policy they stay off until the host has cleared the supply flags with a read-and-clear strobe.

The thermal path works in two stages. A warning flag follows the warning comparator and never touches the outputs. The shutdown comparator must stay asserted for a parameterised number of consecutive cycles before the shutdown flag latches and the outputs go to high impedance. The shutdown flag is released only by a host write of the mode bit to zero, and only once the die has cooled.

Top module: `fault_supervisor`

## Requirements
- R1: While `sup_ov_i` or `sup_uv_i` is high at a clock edge, `out_dis_o` and `fault_o` are high after that edge.
- R2: `sup_ov_i` sets only `ovf_o` and `sup_uv_i` sets only `uvf_o`. Each flag is high after the edge at which its input was high. `fault_o` equals `ovf_o` OR `uvf_o`.
- R3: With `rec_hold_i` = 0 and no shutdown, `out_dis_o` returns low one cycle after both supply inputs are low, even while the supply flags are still set.
- R4: With `rec_hold_i` = 1, `out_dis_o` stays high while either supply flag is set. It drops in the cycle after the flags are cleared.
- R5: `ovf_o` and `uvf_o` are sticky. They clear only at an edge where `sup_rc_i` is high. If the matching fault input is also high at that edge, the flag stays set.
- R6: `twf_o` equals `temp_warn_i` delayed by one cycle. It has no effect on `out_dis_o`.
- R7: `tsdf_o` goes high after `TSD_DLY` consecutive edges with `temp_sd_i` high. A low cycle on `temp_sd_i` restarts the count.
- R8: While `tsdf_o` is high, `out_dis_o` is high. `tsdf_o` clears only at an edge where `mode_wr_i` = 1, `mode_i` = 0 and `temp_sd_i` = 0. A mode write of 1 has no effect on it.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_ov_i | input | 1 | Supply above overvoltage limit |
| sup_uv_i | input | 1 | Supply below undervoltage limit |
| temp_warn_i | input | 1 | Temperature above warning threshold |
| temp_sd_i | input | 1 | Temperature above shutdown threshold |
| rec_hold_i | input | 1 | Supply recovery policy: 0 automatic, 1 hold until flags cleared |
| sup_rc_i | input | 1 | Read-and-clear strobe for the supply status register |
| mode_wr_i | input | 1 | Strobe: host writes the mode bit |
| mode_i | input | 1 | Mode bit value written with `mode_wr_i` |
| out_dis_o | output | 1 | Force all outputs to high impedance |
| fault_o | output | 1 | Global supply fault bit |
| ovf_o | output | 1 | Overvoltage log flag |
| uvf_o | output | 1 | Undervoltage log flag |
| twf_o | output | 1 | Thermal warning flag |
| tsdf_o | output | 1 | Thermal shutdown flag |

## Verification
Overvoltage is driven under the automatic policy and undervoltage under the held policy. This shows that the two policies release the outputs at different times and that each fault sets only its own flag. A clear strobe issued while the fault is still present checks that a set wins over a clear. The shutdown input is held for one cycle less than the delay, then for exactly the delay, and also broken by a single low cycle, which checks the delay boundary and the counter restart. Mode writes are issued while the die is still hot, with value one, and finally with value zero after cooldown, which shows that only the last of these releases the shutdown.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int unsigned NUM_SUP = 2;
  localparam int unsigned IDX_OV  = 0;
  localparam int unsigned IDX_UV  = 1;

  typedef logic [NUM_SUP-1:0] sup_vec_t;
endpackage

// File: rtl/fsup_supply.sv
module fsup_supply
  import fsup_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sup_vec_t fault_i,
  input  logic     rc_i,
  input  logic     hold_i,
  output sup_vec_t flag_o,
  output logic     dis_o
);
  sup_vec_t flag_q;
  logic     live_q;

  for (genvar g = 0; g < NUM_SUP; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q[g] <= 1'b0;
      else if (fault_i[g])  flag_q[g] <= 1'b1;   // set wins over clear
      else if (rc_i)        flag_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= |fault_i;
  end

  assign flag_o = flag_q;
  assign dis_o  = live_q | (hold_i & (|flag_q));
endmodule

// File: rtl/fsup_thermal.sv
module fsup_thermal #(
  parameter int unsigned TSD_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_i,
  input  logic sd_i,
  input  logic release_i,
  output logic warn_o,
  output logic sd_o
);
  localparam int unsigned CNT_W = (TSD_DLY > 1) ? $clog2(TSD_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TSD_DLY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sd_q;
  logic             warn_q;
  logic             rel;

  assign rel = release_i & ~sd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_q <= 1'b0;
    else         warn_q <= warn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sd_q  <= 1'b0;
    end else if (rel) begin
      cnt_q <= '0;
      sd_q  <= 1'b0;
    end else if (!sd_i) begin
      cnt_q <= '0;
    end else if (!sd_q) begin
      if (cnt_q == CNT_LAST) sd_q  <= 1'b1;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign warn_o = warn_q;
  assign sd_o   = sd_q;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned TSD_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_ov_i,
  input  logic sup_uv_i,
  input  logic temp_warn_i,
  input  logic temp_sd_i,
  input  logic rec_hold_i,
  input  logic sup_rc_i,
  input  logic mode_wr_i,
  input  logic mode_i,
  output logic out_dis_o,
  output logic fault_o,
  output logic ovf_o,
  output logic uvf_o,
  output logic twf_o,
  output logic tsdf_o
);
  sup_vec_t sup_fault;
  sup_vec_t sup_flag;
  logic     sup_dis;
  logic     sd_flag;

  assign sup_fault[IDX_OV] = sup_ov_i;
  assign sup_fault[IDX_UV] = sup_uv_i;

  fsup_supply i_supply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (sup_fault),
    .rc_i    (sup_rc_i),
    .hold_i  (rec_hold_i),
    .flag_o  (sup_flag),
    .dis_o   (sup_dis)
  );

  fsup_thermal #(.TSD_DLY(TSD_DLY)) i_thermal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .warn_i    (temp_warn_i),
    .sd_i      (temp_sd_i),
    .release_i (mode_wr_i & ~mode_i),
    .warn_o    (twf_o),
    .sd_o      (sd_flag)
  );

  assign ovf_o     = sup_flag[IDX_OV];
  assign uvf_o     = sup_flag[IDX_UV];
  assign fault_o   = |sup_flag;
  assign tsdf_o    = sd_flag;
  assign out_dis_o = sup_dis | sd_flag;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sup_ov_i,
  input logic sup_uv_i,
  input logic temp_warn_i,
  input logic temp_sd_i,
  input logic rec_hold_i,
  input logic sup_rc_i,
  input logic mode_wr_i,
  input logic mode_i,
  input logic out_dis_o,
  input logic fault_o,
  input logic ovf_o,
  input logic uvf_o,
  input logic twf_o,
  input logic tsdf_o
);
  a_r1_sup_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_ov_i || sup_uv_i) |=> (out_dis_o && fault_o));
  a_r2_ov_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_ov_i |=> ovf_o);
  a_r2_uv_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_uv_i |=> uvf_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_hold_i && (ovf_o || uvf_o)) |-> out_dis_o);
  a_r5_ov_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !sup_rc_i) |=> ovf_o);
  a_r5_uv_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvf_o && !sup_rc_i) |=> uvf_o);
  a_r6_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_warn_i |=> twf_o);
  a_r8_sd_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsdf_o |-> out_dis_o);
  a_r8_sd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsdf_o && !(mode_wr_i && !mode_i && !temp_sd_i)) |=> tsdf_o);
endmodule

bind fault_supervisor fsup_checker i_fsup_checker (.*);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int unsigned DLY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ov = 0, uv = 0, tw = 0, tsd = 0, hold = 0, rc = 0, mwr = 0, mval = 0;
  logic dis, flt, ovf, uvf, twf, tsdf;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.TSD_DLY(DLY)) i_fault_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .sup_ov_i(ov), .sup_uv_i(uv),
    .temp_warn_i(tw), .temp_sd_i(tsd), .rec_hold_i(hold), .sup_rc_i(rc),
    .mode_wr_i(mwr), .mode_i(mval), .out_dis_o(dis), .fault_o(flt),
    .ovf_o(ovf), .uvf_o(uvf), .twf_o(twf), .tsdf_o(tsdf)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 dis", dis, 0); chk("R9 fault", flt, 0);
    chk("R9 ovf", ovf, 0); chk("R9 uvf", uvf, 0);
    chk("R9 twf", twf, 0); chk("R9 tsdf", tsdf, 0);
  endtask

  task automatic t_ov_auto;
    hold = 0; ov = 1; tick();
    chk("R1 dis", dis, 1); chk("R1 fault", flt, 1);
    chk("R2 ovf", ovf, 1); chk("R2 uvf", uvf, 0);
    ov = 0; tick();
    chk("R3 dis", dis, 0); chk("R5 ovf sticky", ovf, 1); chk("R2 fault", flt, 1);
    tick(3);
    chk("R5 ovf still", ovf, 1);
    rc = 1; tick(); rc = 0;
    chk("R5 ovf cleared", ovf, 0); chk("R2 fault cleared", flt, 0);
  endtask

  task automatic t_uv_hold;
    hold = 1; uv = 1; tick();
    chk("R1 dis uv", dis, 1); chk("R2 uvf", uvf, 1); chk("R2 ovf", ovf, 0);
    uv = 0; tick(2);
    chk("R4 dis held", dis, 1);
    rc = 1; tick(); rc = 0;
    chk("R4 uvf cleared", uvf, 0); chk("R4 dis released", dis, 0);
    hold = 0;
  endtask

  task automatic t_rc_during_fault;
    ov = 1; tick();
    rc = 1; tick(); rc = 0;
    chk("R5 set wins", ovf, 1);
    ov = 0; rc = 1; tick(); rc = 0;
    chk("R5 cleared after", ovf, 0);
  endtask

  task automatic t_warn;
    tw = 1; tick();
    chk("R6 twf", twf, 1); chk("R6 no dis", dis, 0);
    tw = 0; tick();
    chk("R6 twf low", twf, 0);
  endtask

  task automatic t_tsd_delay;
    tsd = 1; tick(DLY - 1);
    chk("R7 not yet", tsdf, 0); chk("R7 no dis", dis, 0);
    tsd = 0; tick();
    tsd = 1; tick(DLY - 1);
    chk("R7 restart", tsdf, 0);
    tick();
    chk("R7 set at delay", tsdf, 1); chk("R8 dis", dis, 1);
  endtask

  task automatic t_tsd_release;
    mwr = 1; mval = 0; tick(); mwr = 0;
    chk("R8 hot ignored", tsdf, 1);
    tsd = 0; tick(2);
    chk("R8 stays after cool", tsdf, 1);
    mwr = 1; mval = 1; tick(); mwr = 0;
    chk("R8 mode1 ignored", tsdf, 1); chk("R8 dis kept", dis, 1);
    mwr = 1; mval = 0; tick(); mwr = 0;
    chk("R8 released", tsdf, 0); chk("R8 dis off", dis, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_ov_auto();
    t_uv_hold();
    t_rc_during_fault();
    t_warn();
    t_tsd_delay();
    t_tsd_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule